// File: doc/BRIEF.md
# Gray-Path Thermometer-to-Binary Encoder

This block sits behind a 64-level flash quantizer. It turns the 63-line thermometer word into a 6-bit binary sample. The word is captured in a register when the sample strobe is high. Each Gray-code bit is then formed as an OR of "tap set, higher tap clear" window terms. The top Gray bit is simply the middle line. A ripple XOR chain then turns the Gray code into binary. The result is registered and marked by a one-cycle valid pulse.

Every thermometer line feeds exactly one window term of one Gray bit. A stray zero or one in the word can therefore change at most one Gray bit. Lines with small weight can only move the result by a small amount. An optional serializer can take the current code in parallel and send it out one bit per clock, least significant bit first.

Top module: `therm_gray_encoder`

## Requirements
- R1: After a synchronous active-high reset, `code_o` is 0, and `vld_o`, `ser_o` and `ser_busy_o` are low.
- R2: Bit k-1 of `therm_i` carries line Tk, which is high when the input is at or above level k. A clean word with lines T1..Tc set and all others clear yields `code_o` = c, for every c from 0 to 63 (all zeros gives 0, all ones gives 63).
- R3: When `samp_i` is high at a clock edge, `vld_o` is high for exactly one cycle after the following edge, carrying the code of the word captured at the first edge. `vld_o` is low in every other cycle.
- R4: `code_o` changes only when `vld_o` is raised. Changes on `therm_i` while `samp_i` is low have no effect on `code_o` or `vld_o`.
- R5: For any captured word, valid or not, the code MSB equals line T32 (`therm_i[31]`).
- R6: Take a clean word for level c and invert any single line Tj. The resulting code differs from c by at most 2^(t+1)-1, where t is the number of trailing zero bits of j. Odd lines move the code by at most 1.
- R7: When `ser_load_i` is high at an edge while `ser_busy_o` is low, the serializer loads `code_o`. For the next six cycles it holds `ser_busy_o` high and drives `ser_o` with code bits 0, 1, 2, 3, 4, 5 in that order, one per cycle.
- R8: A `ser_load_i` request while `ser_busy_o` is high is ignored. The bit stream in progress is not altered, even if `code_o` changes meanwhile.
- R9: While `ser_busy_o` is low, `ser_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | 1 | Sample strobe; captures `therm_i` |
| therm_i | input | 63 | Thermometer word, bit k-1 is line Tk |
| ser_load_i | input | 1 | Request to load the code into the serializer |
| code_o | output | 6 | Registered binary code |
| vld_o | output | 1 | One-cycle pulse marking a new code |
| ser_o | output | 1 | Serial data, LSB first, low when idle |
| ser_busy_o | output | 1 | High while a code is being shifted out |

## Verification
The bench sweeps all 64 clean thermometer levels against a ones-count reference. Getting every level right shows that the window strides and the XOR ripple order are correct. It then samples random words with one inverted line and checks the distance from the clean level against the trailing-zero bound; this separates a windowed decoder from one that can jump far. Fully random words check that the MSB follows T32 whatever the pattern. Serial runs are done both idle and with load requests and new samples during a shift, which tells apart a serializer that reloads early from one that keeps the stream.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

   typedef enum logic [0:0] {
      SER_IDLE  = 1'b0,
      SER_SHIFT = 1'b1
   } ser_state_e;

   // number of window terms feeding Gray bit gi for a given resolution
   function automatic int win_count(input int res_bits, input int gi);
      return 1 << (res_bits - 2 - gi);
   endfunction

endpackage

// File: rtl/therm_gray_stage.sv
module therm_gray_stage #(
   parameter int RES_BITS = 6
) (
   input  logic [(1<<RES_BITS)-2:0] therm_i,
   output logic [RES_BITS-1:0]      gray_o
);
   import therm_enc_pkg::*;

   localparam int MID = 1 << (RES_BITS - 1);

   // top Gray bit is the middle line alone
   assign gray_o[RES_BITS-1] = therm_i[MID-1];

   genvar gi, wi;
   generate
      for (gi = 0; gi < RES_BITS - 1; gi++) begin : g_bit
         localparam int STRIDE = 1 << (gi + 2);
         localparam int LO     = 1 << gi;
         localparam int HI_OFF = 1 << (gi + 1);
         localparam int NWIN   = win_count(RES_BITS, gi);
         logic [NWIN-1:0] win;
         for (wi = 0; wi < NWIN; wi++) begin : g_win
            // window active when line LO+k*STRIDE is set but its partner above is clear
            assign win[wi] = therm_i[LO + wi*STRIDE - 1] &
                             ~therm_i[LO + HI_OFF + wi*STRIDE - 1];
         end
         assign gray_o[gi] = |win;
      end
   endgenerate

endmodule

// File: rtl/gray_bin_ripple.sv
module gray_bin_ripple #(
   parameter int RES_BITS = 6
) (
   input  logic [RES_BITS-1:0] gray_i,
   output logic [RES_BITS-1:0] bin_o
);

   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = RES_BITS - 1; i >= 0; i--) begin
         acc      = acc ^ gray_i[i];
         bin_o[i] = acc;
      end
   end

endmodule

// File: rtl/code_serializer.sv
module code_serializer #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] par_i,
   output logic             ser_o,
   output logic             busy_o
);
   import therm_enc_pkg::*;

   localparam int CW = $clog2(WIDTH + 1);

   ser_state_e       state;
   logic [WIDTH-1:0] shreg;
   logic [CW-1:0]    cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SER_IDLE;
         shreg <= '0;
         cnt   <= '0;
      end else begin
         case (state)
            SER_IDLE: begin
               if (load_i) begin
                  shreg <= par_i;
                  cnt   <= CW'(WIDTH);
                  state <= SER_SHIFT;
               end
            end
            SER_SHIFT: begin
               shreg <= shreg >> 1;
               cnt   <= cnt - 1'b1;
               if (cnt == CW'(1)) state <= SER_IDLE;
            end
            default: state <= SER_IDLE;
         endcase
      end
   end

   assign busy_o = (state == SER_SHIFT);
   assign ser_o  = busy_o & shreg[0];

   // R7: an accepted load starts a stream with the LSB of the loaded word
   p_load_starts_r7: assert property (@(posedge clk) disable iff (rst)
      (load_i && !busy_o) |=> (busy_o && ser_o == $past(par_i[0])));

   // R8: while shifting, the next bit comes from the shift register, not a reload
   p_busy_keeps_stream_r8: assert property (@(posedge clk) disable iff (rst)
      (busy_o && cnt > CW'(1)) |=> (busy_o && ser_o == $past(shreg[1])));

   // R7: a stream ends after the final bit
   p_stream_ends_r7: assert property (@(posedge clk) disable iff (rst)
      (busy_o && cnt == CW'(1)) |=> !busy_o);

endmodule

// File: rtl/therm_gray_encoder.sv
module therm_gray_encoder #(
   parameter int RES_BITS = 6,
   parameter bit SER_EN   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       samp_i,
   input  logic [(1<<RES_BITS)-2:0]   therm_i,
   input  logic                       ser_load_i,
   output logic [RES_BITS-1:0]        code_o,
   output logic                       vld_o,
   output logic                       ser_o,
   output logic                       ser_busy_o
);

   localparam int TW  = (1 << RES_BITS) - 1;
   localparam int MID = 1 << (RES_BITS - 1);

   generate
      if (RES_BITS < 2 || RES_BITS > 8) begin : g_bad_res
         $error("therm_gray_encoder: RES_BITS must be within 2..8");
      end
   endgenerate

   logic [TW-1:0]       th_q;
   logic                pend_q;
   logic [RES_BITS-1:0] gray;
   logic [RES_BITS-1:0] bin;

   therm_gray_stage #(.RES_BITS(RES_BITS)) u_gray (
      .therm_i (th_q),
      .gray_o  (gray)
   );

   gray_bin_ripple #(.RES_BITS(RES_BITS)) u_ripple (
      .gray_i (gray),
      .bin_o  (bin)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         th_q   <= '0;
         pend_q <= 1'b0;
         code_o <= '0;
         vld_o  <= 1'b0;
      end else begin
         pend_q <= samp_i;
         if (samp_i) th_q <= therm_i;
         vld_o <= pend_q;
         if (pend_q) code_o <= bin;
      end
   end

   generate
      if (SER_EN) begin : g_ser
         code_serializer #(.WIDTH(RES_BITS)) u_ser (
            .clk    (clk),
            .rst    (rst),
            .load_i (ser_load_i),
            .par_i  (code_o),
            .ser_o  (ser_o),
            .busy_o (ser_busy_o)
         );
      end else begin : g_no_ser
         assign ser_o      = 1'b0;
         assign ser_busy_o = 1'b0;
      end
   endgenerate

   // R3: a strobe produces a valid pulse two edges later
   p_vld_after_samp_r3: assert property (@(posedge clk) disable iff (rst)
      samp_i |=> ##1 vld_o);

   // R3: no strobe, no valid pulse
   p_no_vld_without_samp_r3: assert property (@(posedge clk) disable iff (rst)
      !samp_i |=> ##1 !vld_o);

   // R4: the code holds whenever no new result is flagged
   p_code_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !vld_o |-> $stable(code_o));

   // R5: the MSB of each new code follows the middle thermometer line
   p_msb_is_mid_r5: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> (code_o[RES_BITS-1] == $past(th_q[MID-1])));

endmodule

// File: tb/tb_therm_gray_encoder.sv
module tb_therm_gray_encoder;

   logic        clk = 1'b0;
   logic        rst;
   logic        samp_i;
   logic [62:0] therm_i;
   logic        ser_load_i;
   logic [5:0]  code_o;
   logic        vld_o;
   logic        ser_o;
   logic        ser_busy_o;

   int nchk = 0;
   int nerr = 0;

   therm_gray_encoder #(.RES_BITS(6), .SER_EN(1'b1)) dut (
      .clk        (clk),
      .rst        (rst),
      .samp_i     (samp_i),
      .therm_i    (therm_i),
      .ser_load_i (ser_load_i),
      .code_o     (code_o),
      .vld_o      (vld_o),
      .ser_o      (ser_o),
      .ser_busy_o (ser_busy_o)
   );

   always #4 clk = ~clk;

   function automatic logic [62:0] clean(input int c);
      logic [63:0] x;
      x = (64'd1 << c) - 64'd1;
      return x[62:0];
   endfunction

   function automatic int tz(input int j);
      int t = 0;
      while (((j >> t) & 1) == 0 && t < 6) t++;
      return t;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drives one sample; leaves the new code visible at a falling edge
   task automatic do_sample(input logic [62:0] t);
      @(negedge clk);
      samp_i  = 1'b1;
      therm_i = t;
      @(negedge clk);
      samp_i = 1'b0;
      chk(vld_o == 1'b0, "R3 early vld", vld_o, 0);
      @(negedge clk);
      chk(vld_o == 1'b1, "R3 vld pulse", vld_o, 1);
   endtask

   task automatic ser_run(input logic [5:0] v, input bit interfere, input logic [62:0] t2);
      @(negedge clk);
      ser_load_i = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!interfere) ser_load_i = 1'b0;
         if (interfere && i == 0) begin samp_i = 1'b1; therm_i = t2; end
         if (i == 1) samp_i = 1'b0;
         if (i == 5) ser_load_i = 1'b0;
         chk(ser_busy_o == 1'b1, interfere ? "R8 busy" : "R7 busy", ser_busy_o, 1);
         chk(ser_o == v[i], interfere ? "R8 bit" : "R7 bit", ser_o, v[i]);
      end
      @(negedge clk);
      chk(ser_busy_o == 1'b0, "R7 end of stream", ser_busy_o, 0);
      chk(ser_o == 1'b0, "R9 idle low", ser_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [63:0] r;
      logic [62:0] t;
      logic [5:0]  held;
      int c, j, d, bnd;
      void'($urandom(32'd2024));
      rst = 1'b1; samp_i = 1'b0; therm_i = '0; ser_load_i = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(code_o == 6'd0, "R1 code", code_o, 0);
      chk(vld_o == 1'b0, "R1 vld", vld_o, 0);
      chk(ser_o == 1'b0, "R1 ser", ser_o, 0);
      chk(ser_busy_o == 1'b0, "R1 busy", ser_busy_o, 0);

      // R2 sweep all clean levels
      for (int lv = 0; lv < 64; lv++) begin
         do_sample(clean(lv));
         chk(int'(code_o) == $countones(clean(lv)), "R2 level", code_o, lv);
      end

      // R3 pulse lasts one cycle; R4 input changes without strobe are ignored
      do_sample(clean(21));
      held = code_o;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         therm_i = clean(50 - k);
         chk(vld_o == 1'b0, "R3 single pulse", vld_o, 0);
         chk(code_o == held, "R4 hold", code_o, held);
      end

      // R6 single-line bubbles, directed then random
      do_sample(63'b101);
      chk(int'(code_o) <= 3, "R6 bubble T2", code_o, 3);
      for (int n = 0; n < 150; n++) begin
         c = $urandom_range(0, 63);
         j = $urandom_range(1, 63);
         t = clean(c) ^ (63'd1 << (j - 1));
         do_sample(t);
         d = int'(code_o) - c;
         if (d < 0) d = -d;
         bnd = (1 << (tz(j) + 1)) - 1;
         chk(d <= bnd, "R6 bubble distance", code_o, c);
      end

      // R5 arbitrary words: MSB follows T32
      for (int n = 0; n < 60; n++) begin
         r = {$urandom(), $urandom()};
         do_sample(r[62:0]);
         chk(code_o[5] == r[31], "R5 msb", code_o[5], r[31]);
      end

      // R7 clean serial run, R9 idle
      do_sample(clean(45));
      @(negedge clk);
      chk(ser_o == 1'b0, "R9 idle before load", ser_o, 0);
      ser_run(6'd45, 1'b0, '0);
      do_sample(clean(26));
      ser_run(6'd26, 1'b0, '0);

      // R8 loads and a new sample during shifting do not disturb the stream
      do_sample(clean(57));
      ser_run(6'd57, 1'b1, clean(10));
      chk(code_o == 6'd10, "R8 new code after stream", code_o, 10);
      ser_run(6'd10, 1'b0, '0);

      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule